// File: doc/BRIEF.md
# Motor Feedback Period Discriminator with Lock Flag

This block checks how fast a motor turns. It counts reference ticks between two rising edges of the motor's tachometer feedback, called FG. The reference tick runs at 512 times the commanded clock rate, so a motor turning at the commanded speed gives 512 ticks per feedback period. At the end of each feedback period the block decides whether the motor must speed up, slow down, or hold. It turns that decision into a one-cycle result.

The same decision sets an active-low lock indicator. It also sets a conduction-mode flag for the drive stage: soft conduction while the motor is in lock, and 120-degree conduction while it is out of lock. A small phase comparator reports which of the two rising edges came first: the commanded clock edge or the feedback edge. All inputs are single-cycle pulses that are already synchronous to the system clock.

Top module: `fg_speed_disc`

## Requirements
- R1: While reset is applied and after it is released, lock_n is 1, soft_mode is 0, and disc_valid, disc_up, disc_dn, phase_up and phase_dn are all 0.
- R2: The measured count is the number of cycles with ref_tick high since the previous fg_pulse. A ref_tick in the same cycle as an fg_pulse counts toward the period that fg_pulse starts.
- R3: Each fg_pulse after the first one following reset gives exactly one disc_valid pulse, one cycle wide, two clock edges after the fg_pulse is sampled. The first fg_pulse after reset only starts a measurement and gives no result.
- R4: A count above 544 (motor too slow) raises disc_up together with disc_valid.
- R5: A count below 480 (motor too fast) raises disc_dn together with disc_valid.
- R6: A count from 480 to 544 inclusive raises neither direction, drives lock_n to 0 and drives soft_mode to 1.
- R7: lock_n and soft_mode change only with a result and hold their values between results. An out-of-window result sets lock_n to 1 and soft_mode to 0.
- R8: The period count saturates at 1023, so a stalled or very slow motor reads as 1023 and gives an accelerate decision.
- R9: phase_up goes high the cycle after a clk_edge pulse that arrives while idle and stays high until the cycle after the next fg_pulse. phase_dn does the same with the roles of the two pulses swapped. Pulses that arrive in the same cycle leave both outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick pulse, 512 times the commanded rate |
| fg_pulse | input | 1 | Single-cycle pulse at each feedback rising edge |
| clk_edge | input | 1 | Single-cycle pulse at each commanded-clock rising edge |
| disc_valid | output | 1 | One-cycle pulse that marks a speed result |
| disc_up | output | 1 | Accelerate decision, valid with disc_valid |
| disc_dn | output | 1 | Decelerate decision, valid with disc_valid |
| lock_n | output | 1 | Low while the last period was inside the window |
| soft_mode | output | 1 | 1 selects soft conduction, 0 selects 120-degree conduction |
| phase_up | output | 1 | Commanded clock edge arrived before the feedback edge |
| phase_dn | output | 1 | Feedback edge arrived before the commanded clock edge |

## Verification
The hardest cases to reach are the window edges and saturation. A count of 479, 480, 544 or 545 must land exactly, and a count of 1023 needs over a thousand ticks with no feedback pulse. The driver issues an exact number of ticks per period and tracks in its own model whether a tick shared the feedback cycle. This lets it predict every boundary result, including the carry of one tick into the next period. The phase tests reapply reset, so that a bare feedback pulse first only arms the counter, and then send clock and feedback pulses in both orders and in the same cycle.

// File: rtl/fgsd_pkg.sv
package fgsd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_CLK_FIRST = 2'd1,
    PH_FG_FIRST  = 2'd2
  } ph_state_e;
endpackage

// File: rtl/fgsd_period_counter.sv
module fgsd_period_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             fg_pulse,
  output logic [CNT_W-1:0] meas_cnt,
  output logic             meas_vld
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      armed    <= 1'b0;
      meas_cnt <= '0;
      meas_vld <= 1'b0;
    end else begin
      meas_vld <= fg_pulse && armed;
      if (fg_pulse) begin
        meas_cnt <= run_cnt;
        armed    <= 1'b1;
        run_cnt  <= ref_tick ? CNT_W'(1) : '0;
      end else if (ref_tick && run_cnt != CNT_MAX) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == CNT_MAX && !fg_pulse) |=> run_cnt == CNT_MAX); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!fg_pulse && ref_tick && run_cnt != CNT_MAX) |=> run_cnt == $past(run_cnt) + 1'b1); // R2
  AST_FIRST_EDGE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (fg_pulse && !armed) |=> !meas_vld); // R3
endmodule

// File: rtl/fgsd_window_judge.sv
module fgsd_window_judge #(
  parameter int CNT_W     = 10,
  parameter int NOMINAL   = 512,
  parameter int TOL_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] meas_cnt,
  input  logic             meas_vld,
  output logic             disc_valid,
  output logic             disc_up,
  output logic             disc_dn,
  output logic             lock_n,
  output logic             soft_mode
);
  localparam int TOL = NOMINAL >> TOL_SHIFT;
  localparam int LO  = NOMINAL - TOL;
  localparam int HI  = NOMINAL + TOL;
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI);

  logic too_slow;
  logic too_fast;

  always_comb begin
    too_slow = meas_cnt > HI_C;
    too_fast = meas_cnt < LO_C;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disc_valid <= 1'b0;
      disc_up    <= 1'b0;
      disc_dn    <= 1'b0;
      lock_n     <= 1'b1;
      soft_mode  <= 1'b0;
    end else begin
      disc_valid <= meas_vld;
      disc_up    <= meas_vld && too_slow;
      disc_dn    <= meas_vld && too_fast;
      if (meas_vld) begin
        lock_n    <= too_slow || too_fast;
        soft_mode <= !(too_slow || too_fast);
      end
    end
  end

  AST_RESULT_FOLLOWS_MEAS: assert property (@(posedge clk) disable iff (rst)
    disc_valid |-> $past(meas_vld)); // R3
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    !meas_vld |=> ($stable(lock_n) && $stable(soft_mode))); // R7
endmodule

// File: rtl/fgsd_phase_comp.sv
module fgsd_phase_comp
  import fgsd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clk_edge,
  input  logic fg_pulse,
  output logic phase_up,
  output logic phase_dn
);
  ph_state_e state_q;
  ph_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: begin
        if (clk_edge && !fg_pulse)      state_d = PH_CLK_FIRST;
        else if (fg_pulse && !clk_edge) state_d = PH_FG_FIRST;
      end
      PH_CLK_FIRST: if (fg_pulse) state_d = PH_IDLE;
      PH_FG_FIRST:  if (clk_edge) state_d = PH_IDLE;
      default:      state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PH_IDLE;
    else     state_q <= state_d;
  end

  assign phase_up = (state_q == PH_CLK_FIRST);
  assign phase_dn = (state_q == PH_FG_FIRST);

  AST_UP_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_up) |-> ($past(clk_edge) && !$past(fg_pulse))); // R9
  AST_UP_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_up) |-> $past(fg_pulse)); // R9
  AST_DN_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_dn) |-> $past(clk_edge)); // R9
endmodule

// File: rtl/fg_speed_disc.sv
module fg_speed_disc #(
  parameter int CNT_W     = 10,
  parameter int NOMINAL   = 512,
  parameter int TOL_SHIFT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic fg_pulse,
  input  logic clk_edge,
  output logic disc_valid,
  output logic disc_up,
  output logic disc_dn,
  output logic lock_n,
  output logic soft_mode,
  output logic phase_up,
  output logic phase_dn
);
  logic [CNT_W-1:0] meas_cnt;
  logic             meas_vld;

  fgsd_period_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .fg_pulse(fg_pulse),
    .meas_cnt(meas_cnt), .meas_vld(meas_vld)
  );

  fgsd_window_judge #(.CNT_W(CNT_W), .NOMINAL(NOMINAL), .TOL_SHIFT(TOL_SHIFT)) judge_i (
    .clk(clk), .rst(rst), .meas_cnt(meas_cnt), .meas_vld(meas_vld),
    .disc_valid(disc_valid), .disc_up(disc_up), .disc_dn(disc_dn),
    .lock_n(lock_n), .soft_mode(soft_mode)
  );

  fgsd_phase_comp phase_i (
    .clk(clk), .rst(rst), .clk_edge(clk_edge), .fg_pulse(fg_pulse),
    .phase_up(phase_up), .phase_dn(phase_dn)
  );

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    !(disc_up && disc_dn)); // R4
  AST_DIR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (disc_up || disc_dn) |-> disc_valid); // R5
  AST_LOCK_ON_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (disc_valid && !disc_up && !disc_dn) |-> (!lock_n && soft_mode)); // R6
endmodule

// File: tb/fg_speed_disc_tb_top.sv
module fg_speed_disc_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic fg_pulse = 1'b0;
  logic clk_edge = 1'b0;
  logic disc_valid, disc_up, disc_dn, lock_n, soft_mode, phase_up, phase_dn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int exp_q[$];
  int cnt_q[$];
  int acc = 0;
  bit armed = 1'b0;
  int last_code = -1;

  always #10 clk = ~clk;

  fg_speed_disc dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .fg_pulse(fg_pulse), .clk_edge(clk_edge),
    .disc_valid(disc_valid), .disc_up(disc_up), .disc_dn(disc_dn),
    .lock_n(lock_n), .soft_mode(soft_mode), .phase_up(phase_up), .phase_dn(phase_dn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // code: 2 = accelerate, 1 = decelerate, 0 = locked
  function automatic int classify(input int c);
    int s;
    s = (c > 1023) ? 1023 : c;
    if (s > 544) return 2;
    if (s < 480) return 1;
    return 0;
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_tick = 1'b1;
      acc++;
    end
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic send_fg(input bit ovl, input bit ce);
    @(negedge clk);
    fg_pulse = 1'b1;
    ref_tick = ovl;
    clk_edge = ce;
    if (armed) begin
      exp_q.push_back(classify(acc));
      cnt_q.push_back(acc);
      last_code = classify(acc);
    end
    armed = 1'b1;
    acc = ovl ? 1 : 0;
    @(negedge clk);
    fg_pulse = 1'b0;
    ref_tick = 1'b0;
    clk_edge = 1'b0;
  endtask

  task automatic hold_check();
    repeat (3) @(negedge clk);
    if (last_code >= 0) begin
      chk("R7 lock_n held", lock_n, (last_code == 0) ? 0 : 1);
      chk("R7 soft_mode held", soft_mode, (last_code == 0) ? 1 : 0);
    end
  endtask

  task automatic period(input int n, input bit ovl);
    ticks(n);
    send_fg(ovl, 1'b0);
    hold_check();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    armed = 1'b0;
    acc = 0;
    last_code = -1;
  endtask

  // monitor: pops expected results as the design produces them
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && disc_valid) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected result", 1, 0);
        end else begin
          int e;
          int c;
          e = exp_q.pop_front();
          c = cnt_q.pop_front();
          chk($sformatf("R4 disc_up count=%0d", c), disc_up, (e == 2) ? 1 : 0);
          chk($sformatf("R5 disc_dn count=%0d", c), disc_dn, (e == 1) ? 1 : 0);
          chk($sformatf("R6 lock_n count=%0d", c), lock_n, (e == 0) ? 0 : 1);
          chk($sformatf("R6 soft_mode count=%0d", c), soft_mode, (e == 0) ? 1 : 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 lock_n", lock_n, 1);
    chk("R1 soft_mode", soft_mode, 0);
    chk("R1 disc_valid", disc_valid, 0);
    chk("R1 phase", {phase_up, phase_dn}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 lock_n after release", lock_n, 1);

    // R3: first fg only arms
    ticks(512);
    send_fg(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R3 no result on first fg", exp_q.size(), 0);
    chk("R1 still unlocked before first result", lock_n, 1);

    period(512, 1'b0);   // R6 nominal
    period(479, 1'b0);   // R5 boundary
    period(480, 1'b0);   // R6 lower edge
    period(544, 1'b0);   // R6 upper edge
    period(545, 1'b0);   // R4 boundary
    period(300, 1'b0);   // R5 fast
    period(700, 1'b0);   // R4 slow
    period(511, 1'b1);   // R2 overlap tick carries
    period(543, 1'b0);   // R2 543 + 1 carried = 544 -> locked
    period(1100, 1'b0);  // R8 saturate
    period(520, 1'b0);   // back to lock
    period(1023, 1'b0);  // R8 exact max
    repeat (4) @(negedge clk);
    chk("R3 all results seen", exp_q.size(), 0);

    // R9 phase comparator
    do_reset();
    @(negedge clk);
    clk_edge = 1'b1;
    @(negedge clk);
    clk_edge = 1'b0;
    chk("R9 phase_up after clk first", phase_up, 1);
    chk("R9 phase_dn idle", phase_dn, 0);
    repeat (2) @(negedge clk);
    chk("R9 phase_up held", phase_up, 1);
    send_fg(1'b0, 1'b0);
    chk("R9 phase_up cleared by fg", phase_up, 0);
    send_fg(1'b0, 1'b0);
    chk("R9 phase_dn after fg first", phase_dn, 1);
    chk("R9 phase_up low", phase_up, 0);
    @(negedge clk);
    clk_edge = 1'b1;
    @(negedge clk);
    clk_edge = 1'b0;
    chk("R9 phase_dn cleared by clk", phase_dn, 0);
    send_fg(1'b0, 1'b1);
    chk("R9 simultaneous idle", {phase_up, phase_dn}, 0);
    repeat (4) @(negedge clk);
    chk("R3 phase section results seen", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule